// File: doc/BRIEF.md
# Two-Stage Pipelined Instruction Cache

This block is a read-only, direct-mapped instruction cache for a processor front end. Each fetch is split over two pipeline cycles. In the first cycle the fetch address is presented and compared against the stored tag. In the second cycle the selected instruction word comes out of a registered data path with a valid flag. A new fetch can be presented in every cycle, so a run of hits returns one instruction per cycle.

When a lookup misses, the cache asserts `stall` so that the fetch stage keeps its address steady. It then requests the whole 16-byte line from a backing memory over a one-line refill port. When the line arrives it is written into the data array, and its tag and valid bit are set. In the same cycle the requested word is forwarded into the output stage. With a memory that answers one cycle after the request, a miss keeps the request in the first stage for three cycles in total.

A kill input lets later pipeline stages discard the word that is currently in the output stage. A synchronous flush input invalidates the whole cache in one cycle.

Top module: `fetch_icache`

## Requirements
- R1: After reset every line is invalid: `stall`, `inst_valid` and `refill_req` are low while no fetch is presented, and the first fetch to any line misses.
- R2: A fetch that hits in cycle t leaves `stall` low in cycle t. In cycle t+1, `inst_valid` is high and `inst_word` holds the word stored at that address.
- R3: Hits presented in consecutive cycles are each answered one cycle later, with no gap and no stall.
- R4: A missing fetch presented in cycle t holds `stall` high in cycles t, t+1 and t+2 when the memory replies one cycle after the request. `stall` is low in t+3, and in t+3 the requested word is on `inst_word` with `inst_valid` high.
- R5: Each miss produces exactly one `refill_req` pulse, lasting a single cycle and falling inside the stall window. While the pulse is high, `refill_addr` is the fetch address with bits [3:0] cleared.
- R6: `refill_line` carries word k of the line in bits [32k+31:32k]. Address bits [3:2] select the word. One refill fills all four words, so the other three words of that line then hit.
- R7: Address bits [6:4] select one of eight lines and bits [31:7] form the tag. A fetch with the same index and a different tag misses and replaces the line, so the previous address misses again afterwards.
- R8: `kill` forces `inst_valid` low in the cycle it is high. A kill during a miss leaves the refill unaffected, and the line is still installed.
- R9: A `flush` pulse invalidates every line in one cycle. Every lookup after it misses until the line is refilled.
- R10: A cycle with `fetch_valid` low performs no lookup. It raises no stall or refill request, and `inst_valid` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_addr | input | 32 | Byte fetch address, word aligned |
| kill | input | 1 | Discard the word in the output stage |
| flush | input | 1 | Invalidate all lines |
| stall | output | 1 | Miss in service; hold the fetch address |
| inst_valid | output | 1 | `inst_word` holds a delivered instruction |
| inst_word | output | 32 | Instruction word from the output stage |
| refill_req | output | 1 | One-cycle request for a line |
| refill_addr | output | 32 | Line-aligned address of the requested line |
| refill_valid | input | 1 | `refill_line` holds the requested line |
| refill_line | input | 128 | Whole line, word k in bits [32k+31:32k] |

## Verification
The hardest situation to reach is a miss whose window overlaps other activity. Examples are a kill raised during the three stall cycles, or a conflicting tag evicting a line that has just been filled. The bench first sweeps every word of all eight lines, which yields one compulsory miss per line followed by hits. It then sweeps a second region that maps onto the same indices, with kill held high during alternate misses. Finally it returns to the first region, so the conflict misses and the survival of a killed refill both show up at the ports.

// File: rtl/icache_pkg.sv
package icache_pkg;

  // Miss-service sequencer states
  typedef enum logic [1:0] {
    MC_IDLE = 2'd0,   // lookups accepted
    MC_REQ  = 2'd1,   // refill request on the port
    MC_WAIT = 2'd2    // waiting for the line
  } mc_state_t;

endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
  parameter int LINES = 8,
  parameter int TAG_W = 25,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             hit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);

  logic [LINES-1:0] vld;
  logic [TAG_W-1:0] tags [LINES];

  // One valid bit per line; flush has priority over a fill in the same cycle
  for (genvar g = 0; g < LINES; g++) begin : g_vld
    always_ff @(posedge clk) begin
      if (rst || flush)
        vld[g] <= 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        vld[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en)
      tags[wr_idx] <= wr_tag;
  end

  assign hit = vld[rd_idx] && (tags[rd_idx] == rd_tag);

endmodule

// File: rtl/icache_line_store.sv
module icache_line_store #(
  parameter int LINES  = 8,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line
);

  logic [LINE_W-1:0] mem [LINES];

  // Simple dual-port RAM: full-line write, registered full-line read
  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wr_idx] <= wr_line;
  end

  always_ff @(posedge clk) begin
    if (rd_en)
      rd_line <= mem[rd_idx];
  end

endmodule

// File: rtl/icache_miss_ctl.sv
module icache_miss_ctl
  import icache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 2,
  parameter int WSEL_W = 2,
  parameter int IDX_W  = 3,
  localparam int OFF_W = BYTE_W + WSEL_W,
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int WA_W  = ADDR_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lookup,
  input  logic              hit,
  input  logic [WA_W-1:0]   lookup_waddr,
  input  logic              refill_valid,
  output logic              stall,
  output logic              refill_req,
  output logic [ADDR_W-1:0] refill_addr,
  output logic              fill,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [TAG_W-1:0]  fill_tag,
  output logic [WSEL_W-1:0] fill_wsel
);

  mc_state_t st, st_nx;
  logic [WA_W-1:0] miss_q;
  logic            miss_now;

  assign miss_now = (st == MC_IDLE) && lookup && !hit;

  always_comb begin
    st_nx = st;
    case (st)
      MC_IDLE: if (miss_now)     st_nx = MC_REQ;
      MC_REQ:                    st_nx = MC_WAIT;
      MC_WAIT: if (refill_valid) st_nx = MC_IDLE;
      default:                   st_nx = MC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      st <= MC_IDLE;
    else
      st <= st_nx;
  end

  always_ff @(posedge clk) begin
    if (miss_now)
      miss_q <= lookup_waddr;
  end

  assign stall       = miss_now || (st != MC_IDLE);
  assign refill_req  = (st == MC_REQ);
  assign refill_addr = {miss_q[WA_W-1:WSEL_W], {OFF_W{1'b0}}};
  assign fill        = (st == MC_WAIT) && refill_valid;
  assign fill_wsel   = miss_q[WSEL_W-1:0];
  assign fill_idx    = miss_q[WSEL_W +: IDX_W];
  assign fill_tag    = miss_q[WA_W-1 -: TAG_W];

endmodule

// File: rtl/fetch_icache.sv
module fetch_icache
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINES      = 8,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         fetch_valid,
  input  logic [ADDR_W-1:0]            fetch_addr,
  input  logic                         kill,
  input  logic                         flush,
  output logic                         stall,
  output logic                         inst_valid,
  output logic [WORD_W-1:0]            inst_word,
  output logic                         refill_req,
  output logic [ADDR_W-1:0]            refill_addr,
  input  logic                         refill_valid,
  input  logic [LINE_WORDS*WORD_W-1:0] refill_line
);

  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = BYTE_W + WSEL_W;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = LINE_WORDS * WORD_W;

  // Stage 1 address fields
  logic [IDX_W-1:0]  f_idx;
  logic [TAG_W-1:0]  f_tag;
  logic [WSEL_W-1:0] f_wsel;
  logic              unused_byte_bits;

  assign f_idx            = fetch_addr[OFF_W +: IDX_W];
  assign f_tag            = fetch_addr[ADDR_W-1 -: TAG_W];
  assign f_wsel           = fetch_addr[BYTE_W +: WSEL_W];
  assign unused_byte_bits = ^fetch_addr[BYTE_W-1:0];

  logic              tag_hit;
  logic              fill;
  logic [IDX_W-1:0]  fill_idx;
  logic [TAG_W-1:0]  fill_tag;
  logic [WSEL_W-1:0] fill_wsel;
  logic              advance;
  logic [LINE_W-1:0] rd_line;

  icache_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .rd_idx (f_idx),
    .rd_tag (f_tag),
    .hit    (tag_hit),
    .wr_en  (fill),
    .wr_idx (fill_idx),
    .wr_tag (fill_tag)
  );

  icache_miss_ctl #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .WSEL_W (WSEL_W),
    .IDX_W  (IDX_W)
  ) u_ctl (
    .clk          (clk),
    .rst          (rst),
    .lookup       (fetch_valid),
    .hit          (tag_hit),
    .lookup_waddr (fetch_addr[ADDR_W-1:BYTE_W]),
    .refill_valid (refill_valid),
    .stall        (stall),
    .refill_req   (refill_req),
    .refill_addr  (refill_addr),
    .fill         (fill),
    .fill_idx     (fill_idx),
    .fill_tag     (fill_tag),
    .fill_wsel    (fill_wsel)
  );

  // A hit leaves stage 1 whenever a fetch is presented and nothing stalls
  assign advance = fetch_valid && !stall;

  icache_line_store #(.LINES(LINES), .LINE_W(LINE_W)) u_data (
    .clk     (clk),
    .wr_en   (fill),
    .wr_idx  (fill_idx),
    .wr_line (refill_line),
    .rd_en   (advance),
    .rd_idx  (f_idx),
    .rd_line (rd_line)
  );

  // Word views of the incoming and the stored line
  logic [WORD_W-1:0] refill_words [LINE_WORDS];
  logic [WORD_W-1:0] stored_words [LINE_WORDS];

  for (genvar g = 0; g < LINE_WORDS; g++) begin : g_words
    assign refill_words[g] = refill_line[g*WORD_W +: WORD_W];
    assign stored_words[g] = rd_line[g*WORD_W +: WORD_W];
  end

  // Stage 2: registered valid, word select and refill bypass
  logic              s2_valid;
  logic              use_byp;
  logic [WORD_W-1:0] byp_word;
  logic [WSEL_W-1:0] wsel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      use_byp  <= 1'b0;
    end else begin
      s2_valid <= fill || advance;
      use_byp  <= fill;
    end
    if (fill)
      byp_word <= refill_words[fill_wsel];
    if (advance)
      wsel_q <= f_wsel;
  end

  assign inst_word  = use_byp ? byp_word : stored_words[wsel_q];
  assign inst_valid = s2_valid && !kill;

endmodule

// File: rtl/fetch_icache_chk.sv
module fetch_icache_chk #(
  parameter int OFF_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             fetch_valid,
  input logic             stall,
  input logic             kill,
  input logic             flush,
  input logic             inst_valid,
  input logic             refill_req,
  input logic             tag_hit,
  input logic [OFF_W-1:0] req_off
);

  // R2
  hit_answers_next_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_valid && !stall |=> inst_valid || kill);

  // R4
  req_inside_stall_chk: assert property (@(posedge clk) disable iff (rst)
    refill_req |-> stall);

  // R5
  req_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    refill_req |=> !refill_req);

  // R5
  req_after_miss_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(refill_req) |-> $past(stall));

  // R5
  req_line_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    refill_req |-> (req_off == '0));

  // R8
  kill_masks_chk: assert property (@(posedge clk) disable iff (rst)
    kill |-> !inst_valid);

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(flush) |-> !tag_hit);

  // R10
  idle_no_output_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid && !stall |=> !inst_valid);

endmodule

bind fetch_icache fetch_icache_chk #(.OFF_W(OFF_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fetch_valid (fetch_valid),
  .stall       (stall),
  .kill        (kill),
  .flush       (flush),
  .inst_valid  (inst_valid),
  .refill_req  (refill_req),
  .tag_hit     (tag_hit),
  .req_off     (refill_addr[OFF_W-1:0])
);

// File: tb/fetch_icache_test.sv
module fetch_icache_test;

  logic         clk = 1'b0;
  logic         rst;
  logic         fetch_valid;
  logic [31:0]  fetch_addr;
  logic         kill;
  logic         flush;
  logic         stall;
  logic         inst_valid;
  logic [31:0]  inst_word;
  logic         refill_req;
  logic [31:0]  refill_addr;
  logic         refill_valid;
  logic [127:0] refill_line;

  int checks = 0;
  int errors = 0;
  int req_count = 0;
  logic [31:0] last_req_addr;
  bit   done = 1'b0;

  // Bench view of cache contents
  bit          mv [8];
  logic [24:0] mt [8];

  always #5 clk = ~clk;

  fetch_icache uut (
    .clk          (clk),
    .rst          (rst),
    .fetch_valid  (fetch_valid),
    .fetch_addr   (fetch_addr),
    .kill         (kill),
    .flush        (flush),
    .stall        (stall),
    .inst_valid   (inst_valid),
    .inst_word    (inst_word),
    .refill_req   (refill_req),
    .refill_addr  (refill_addr),
    .refill_valid (refill_valid),
    .refill_line  (refill_line)
  );

  function automatic logic [31:0] word_at(input logic [31:0] a);
    logic [31:0] wa;
    wa = {a[31:2], 2'b00};
    return (wa * 32'd2654435761) ^ 32'h3C96_A55A;
  endfunction

  function automatic logic [127:0] line_at(input logic [31:0] a);
    logic [127:0] l;
    for (int k = 0; k < 4; k++)
      l[k*32 +: 32] = word_at({a[31:4], 4'(k * 4)});
    return l;
  endfunction

  // Backing memory: answers one cycle after the request
  always @(posedge clk) begin
    if (rst) begin
      refill_valid <= 1'b0;
    end else begin
      refill_valid <= refill_req;
      if (refill_req) begin
        refill_line   <= line_at(refill_addr);
        last_req_addr <= refill_addr;
        req_count     <= req_count + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One isolated fetch; optional kill held through a miss window
  task automatic do_fetch(input logic [31:0] a, input bit kill_in_miss, input string req);
    bit exp_hit;
    int n;
    int req_before;
    exp_hit = mv[a[6:4]] && (mt[a[6:4]] == a[31:7]);
    req_before = req_count;
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr  = a;
    #1;
    check(stall == !exp_hit, req, 32'(stall), 32'(!exp_hit));
    if (stall) begin
      kill = kill_in_miss;
      n = 0;
      while (stall && n < 10) begin
        @(negedge clk);
        n++;
        #1;
      end
      fetch_valid = 1'b0;
      kill = 1'b0;
      #1;
      check(n == 3, "R4 stall length", 32'(n), 32'd3);
      check(inst_valid && inst_word == word_at(a), "R4 miss word",
            inst_word, word_at(a));
      check(last_req_addr == {a[31:4], 4'h0}, "R5 refill address",
            last_req_addr, {a[31:4], 4'h0});
      check(req_count == req_before + 1, "R5 one request",
            32'(req_count - req_before), 32'd1);
      mv[a[6:4]] = 1'b1;
      mt[a[6:4]] = a[31:7];
    end else begin
      @(negedge clk);
      fetch_valid = 1'b0;
      #1;
      check(inst_valid && inst_word == word_at(a), req, inst_word, word_at(a));
    end
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int rc;
    rst = 1'b1;
    fetch_valid = 1'b0;
    fetch_addr = '0;
    kill = 1'b0;
    flush = 1'b0;
    for (int i = 0; i < 8; i++) begin
      mv[i] = 1'b0;
      mt[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check(!stall && !inst_valid && !refill_req, "R1 reset outputs",
          {29'd0, stall, inst_valid, refill_req}, 32'd0);

    // R10: no fetch presented, no lookup
    @(negedge clk);
    fetch_addr = 32'h0000_0100;
    #1;
    check(!stall, "R10 no stall without fetch", 32'(stall), 32'd0);
    @(negedge clk);
    #1;
    check(!inst_valid && req_count == 0, "R10 no output without fetch",
          {31'd0, inst_valid}, 32'd0);

    // R1/R6: sweep every word of all eight lines (compulsory misses then hits)
    for (int l = 0; l < 8; l++)
      for (int w = 0; w < 4; w++)
        do_fetch(32'h0000_0100 + 32'(l * 16 + w * 4), 1'b0, "R6 line sweep");

    // R3: back-to-back hits
    for (int i = 0; i <= 32; i++) begin
      @(negedge clk);
      if (i < 32) begin
        fetch_valid = 1'b1;
        fetch_addr  = 32'h0000_0100 + 32'(i * 4);
      end else begin
        fetch_valid = 1'b0;
      end
      #1;
      if (i < 32)
        check(!stall, "R3 no stall on streaming hits", 32'(stall), 32'd0);
      if (i > 0)
        check(inst_valid && inst_word == word_at(32'h0000_0100 + 32'((i - 1) * 4)),
              "R3 streaming word", inst_word,
              word_at(32'h0000_0100 + 32'((i - 1) * 4)));
    end

    // R8: kill masks a hit's output in its output cycle
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr  = 32'h0000_0114;
    @(negedge clk);
    fetch_valid = 1'b0;
    kill = 1'b1;
    #1;
    check(!inst_valid, "R8 kill masks output", {31'd0, inst_valid}, 32'd0);
    kill = 1'b0;
    #1;
    check(inst_valid && inst_word == word_at(32'h0000_0114), "R8 unkilled word",
          inst_word, word_at(32'h0000_0114));

    // R7/R8: conflicting region, kill during every other miss
    for (int l = 0; l < 8; l++)
      do_fetch(32'hFFFF_FF80 + 32'(l * 16 + 8), (l % 2) == 1, "R7 conflict fill");
    for (int l = 0; l < 8; l++)
      do_fetch(32'hFFFF_FF80 + 32'(l * 16 + 4), 1'b0, "R8 killed refill kept");
    for (int l = 0; l < 8; l++)
      do_fetch(32'h0000_0100 + 32'(l * 16 + 12), 1'b0, "R7 evicted line misses");

    // R9: flush then every line misses again
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < 8; i++)
      mv[i] = 1'b0;
    rc = req_count;
    for (int l = 0; l < 8; l++)
      do_fetch(32'h0000_0100 + 32'(l * 16), 1'b0, "R9 miss after flush");
    check(req_count == rc + 8, "R9 refills after flush", 32'(req_count - rc), 32'd8);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule